// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a narrow host access port and a register file whose control registers are 128 bits wide, plus a table of 64-bit memory entries. A host that can only issue 32-bit or 64-bit accesses still needs every wide register to change in one step. The block therefore gathers the leading words of a wide write in a single collector. It drives the register file with the complete value, in a one-cycle write pulse, only when the final word arrives. Memory entries work the same way with two words.

Reads go the other way. Reading the first word of a wide register (or the lower word of a memory entry) returns the live value and copies the whole entry into a shadow register. The later words are then served from that shadow, so the host gets a consistent value even if the register changes between its accesses. A few pointer-style registers are dword registers: a lone 32-bit write reaches them at once, without passing through the collector, and it does not disturb a collection that is open.

The address space has two regions, selected by the top address bit. The register region is split into pages of 0x2000 bytes, and each page holds 16-byte register slots. The memory region holds 8-byte entries.

Top module: `wide_reg_collector`

## Requirements
- R1: A wide register occupies slot S (S < NUM_WIDE) of page P, at byte address P*0x2000 + S*16 + 4*k for word k. 32-bit writes of words 0, 1 and 2 produce no output pulse. A 32-bit write of word 3 to the same register produces `rf_we` high for exactly one cycle, on the cycle after the write, with `rf_wdata` = {w3, w2, w1, w0}.
- R2: A 64-bit write at offset 0 of a wide register collects words 0 and 1 from `bus_wdata`. A 64-bit write at offset 8 of the same register commits `rf_wdata` = {data at offset 8, data at offset 0}. A 64-bit write at offset 4 or 12 is ignored.
- R3: There is one collector. A word-0 write (32-bit or 64-bit) opens a new collection, which discards any partial value and clears the uncollected words to zero. A write of words 1 to 3 (or a 64-bit write at offset 8) is dropped, with no pulse, when no collection is open or when the open one belongs to a different register.
- R4: The memory region has address bit AW-1 set. An entry's index is held in address bits [AW-2:3], and address bit 2 selects its upper word. A 32-bit lower-word write is collected. The matching 32-bit upper-word write pulses `mem_we` with {upper, lower}. A 64-bit write at the lower word commits the entry directly and leaves the collector unchanged.
- R5: The dword registers are slots DW_SLOT_BASE to DW_SLOT_BASE+NUM_DW-1 of each page, at word offset 0. A 32-bit write to one of them pulses `dw_we` on the next cycle, with `dw_waddr` = {page, slot-DW_SLOT_BASE} and the 32-bit data.
- R6: A dword register write that lands between the words of an open wide collection neither commits nor alters it. The later last-word write still commits every word collected earlier.
- R7: The page number is address bits [AW-2:13], and `rf_waddr` = {page, slot}. A commit to a register in any page carries that page in its address.
- R8: Every read returns `rd_valid` with `rd_data` one cycle after the request. A 32-bit read of word 0 returns the live word 0 and snapshots all 128 bits. A 32-bit read of word 1, 2 or 3 returns that word of the snapshot, even if the register was changed after the snapshot. The upper 32 bits of a 32-bit read are zero.
- R9: A 64-bit read at offset 0 of a wide register returns the live lower 64 bits and snapshots all 128 bits. A 64-bit read at offset 8 returns the upper 64 bits of the snapshot.
- R10: A 32-bit read of a memory entry's lower word returns that word live and snapshots the 64-bit entry. A 32-bit read of the upper word returns the snapshot's upper word. A 64-bit read at the lower word returns the live entry.
- R11: Reads of unmapped addresses, and of dword registers, return zero. Unmapped addresses are slots outside both ranges, dword slots at a nonzero word, and any address with nonzero bits [1:0]. Writes to unmapped addresses produce no pulse and leave an open collection intact.
- R12: Out of reset no write pulse and no read response is active, and at most one of `rf_we`, `mem_we` and `dw_we` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr | input | AW (1+PAGE_W+13) | Byte address |
| bus_wdata | input | 64 | Write data (32-bit accesses use bits 31:0) |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 64 | Read response data |
| rf_raddr | output | PAGE_W+9 | Register file read index |
| rf_rdata | input | 128 | Live register value at `rf_raddr` |
| rf_we | output | 1 | Wide register commit pulse |
| rf_waddr | output | PAGE_W+9 | Committed register index {page, slot} |
| rf_wdata | output | 128 | Committed register value |
| mem_raddr | output | AW-4 | Memory entry read index |
| mem_rdata | input | 64 | Live memory entry at `mem_raddr` |
| mem_we | output | 1 | Memory entry commit pulse |
| mem_waddr | output | AW-4 | Committed entry index |
| mem_wdata | output | 64 | Committed entry value |
| dw_we | output | 1 | Dword register write pulse |
| dw_waddr | output | PAGE_W+DSEL_W | Dword register index {page, select} |
| dw_wdata | output | 32 | Dword register value |

## Verification
The bench builds the block with PAGE_W=2, NUM_WIDE=4, DW_SLOT_BASE=8 and NUM_DW=3. These values give four pages and three dword registers per page. They also leave an unmapped gap of slots 4 to 7 between the wide and dword ranges, which lets unmapped writes be placed in the middle of an open collection. With four pages, a commit to page 3 exercises every page bit in the register index. The small dword range means a write to a dword slot at a nonzero word lands just past a real register.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  // Byte span of one register page; the page number sits above these bits.
  localparam int OFS_W  = 13;
  // Register slots are 16 bytes, so the slot field is the offset above bit 3.
  localparam int SLOT_W = OFS_W - 4;

  typedef enum logic [1:0] {
    AK_NONE  = 2'd0,
    AK_WIDE  = 2'd1,
    AK_DWORD = 2'd2,
    AK_MEM   = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/wrc_decode.sv
module wrc_decode
  import wrc_pkg::*;
#(
  parameter int PAGE_W       = 2,
  parameter int NUM_WIDE     = 8,
  parameter int DW_SLOT_BASE = 256,
  parameter int NUM_DW       = 3,
  localparam int AW          = 1 + PAGE_W + OFS_W,
  localparam int RIDX_W      = PAGE_W + SLOT_W,
  localparam int DSEL_W      = (NUM_DW > 1) ? $clog2(NUM_DW) : 1,
  localparam int DIDX_W      = PAGE_W + DSEL_W,
  localparam int MIDX_W      = AW - 4
) (
  input  logic [AW-1:0]     addr,
  output acc_kind_e         kind,
  output logic [1:0]        word,
  output logic [RIDX_W-1:0] ridx,
  output logic [DIDX_W-1:0] didx,
  output logic [MIDX_W-1:0] midx
);
  logic [PAGE_W-1:0] page;
  logic [SLOT_W-1:0] slot;
  logic [DSEL_W-1:0] dsel;
  logic              aligned;

  assign page    = addr[AW-2 -: PAGE_W];
  assign slot    = addr[OFS_W-1:4];
  assign dsel    = DSEL_W'(slot - SLOT_W'(DW_SLOT_BASE));
  assign aligned = (addr[1:0] == 2'b00);
  assign ridx    = {page, slot};
  assign didx    = {page, dsel};
  assign midx    = addr[AW-2:3];

  always_comb begin
    kind = AK_NONE;
    word = addr[3:2];
    if (!aligned) begin
      kind = AK_NONE;
    end else if (addr[AW-1]) begin
      kind = AK_MEM;
      word = {1'b0, addr[2]};
    end else if (32'(slot) < 32'(NUM_WIDE)) begin
      kind = AK_WIDE;
    end else if (32'(slot) >= 32'(DW_SLOT_BASE) &&
                 32'(slot) < 32'(DW_SLOT_BASE + NUM_DW) &&
                 addr[3:2] == 2'd0) begin
      kind = AK_DWORD;
    end
  end
endmodule

// File: rtl/wrc_collect.sv
module wrc_collect
  import wrc_pkg::*;
#(
  parameter int RIDX_W = 11,
  parameter int MIDX_W = 12,
  parameter int DIDX_W = 4,
  localparam int IDX_W = (RIDX_W > MIDX_W) ? RIDX_W : MIDX_W,
  localparam int TGT_W = 1 + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic              wide64,
  input  acc_kind_e         kind,
  input  logic [1:0]        word,
  input  logic [RIDX_W-1:0] ridx,
  input  logic [DIDX_W-1:0] didx,
  input  logic [MIDX_W-1:0] midx,
  input  logic [63:0]       wdata,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_waddr,
  output logic [127:0]      rf_wdata,
  output logic              mem_we,
  output logic [MIDX_W-1:0] mem_waddr,
  output logic [63:0]       mem_wdata,
  output logic              dw_we,
  output logic [DIDX_W-1:0] dw_waddr,
  output logic [31:0]       dw_wdata
);
  logic              act_q, act_n;
  logic [TGT_W-1:0]  tgt_q, tgt_n, tgt_in;
  logic [95:0]       dat_q, dat_n;
  logic              rfwe_n, mwe_n, dwe_n;
  logic [RIDX_W-1:0] rfa_n;
  logic [127:0]      rfd_n;
  logic [MIDX_W-1:0] ma_n;
  logic [63:0]       md_n;
  logic [DIDX_W-1:0] da_n;
  logic [31:0]       dd_n;
  logic              hit;

  assign tgt_in = (kind == AK_MEM) ? {1'b1, IDX_W'(midx)} : {1'b0, IDX_W'(ridx)};
  assign hit    = act_q && (tgt_q == tgt_in);

  always_comb begin
    act_n  = act_q;
    tgt_n  = tgt_q;
    dat_n  = dat_q;
    rfwe_n = 1'b0;
    rfa_n  = rf_waddr;
    rfd_n  = rf_wdata;
    mwe_n  = 1'b0;
    ma_n   = mem_waddr;
    md_n   = mem_wdata;
    dwe_n  = 1'b0;
    da_n   = dw_waddr;
    dd_n   = dw_wdata;
    if (wr_go) begin
      unique case (kind)
        AK_WIDE: begin
          if (!wide64) begin
            if (word == 2'd0) begin
              act_n = 1'b1;
              tgt_n = tgt_in;
              dat_n = {64'b0, wdata[31:0]};
            end else if (word == 2'd3) begin
              if (hit) begin
                rfwe_n = 1'b1;
                rfa_n  = ridx;
                rfd_n  = {wdata[31:0], dat_q};
                act_n  = 1'b0;
              end
            end else if (hit) begin
              dat_n[{word, 5'd0} +: 32] = wdata[31:0];
            end
          end else if (word == 2'd0) begin
            act_n = 1'b1;
            tgt_n = tgt_in;
            dat_n = {32'b0, wdata};
          end else if (word == 2'd2 && hit) begin
            rfwe_n = 1'b1;
            rfa_n  = ridx;
            rfd_n  = {wdata, dat_q[63:0]};
            act_n  = 1'b0;
          end
        end
        AK_MEM: begin
          if (!wide64) begin
            if (!word[0]) begin
              act_n = 1'b1;
              tgt_n = tgt_in;
              dat_n = {64'b0, wdata[31:0]};
            end else if (hit) begin
              mwe_n = 1'b1;
              ma_n  = midx;
              md_n  = {wdata[31:0], dat_q[31:0]};
              act_n = 1'b0;
            end
          end else if (!word[0]) begin
            mwe_n = 1'b1;
            ma_n  = midx;
            md_n  = wdata;
          end
        end
        AK_DWORD: begin
          if (!wide64) begin
            dwe_n = 1'b1;
            da_n  = didx;
            dd_n  = wdata[31:0];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      tgt_q     <= '0;
      dat_q     <= '0;
      rf_we     <= 1'b0;
      rf_waddr  <= '0;
      rf_wdata  <= '0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      dw_we     <= 1'b0;
      dw_waddr  <= '0;
      dw_wdata  <= '0;
    end else begin
      act_q     <= act_n;
      tgt_q     <= tgt_n;
      dat_q     <= dat_n;
      rf_we     <= rfwe_n;
      rf_waddr  <= rfa_n;
      rf_wdata  <= rfd_n;
      mem_we    <= mwe_n;
      mem_waddr <= ma_n;
      mem_wdata <= md_n;
      dw_we     <= dwe_n;
      dw_waddr  <= da_n;
      dw_wdata  <= dd_n;
    end
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, mem_we, dw_we})); // R12
  AST_COMMIT_FROM_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(act_q)); // R3
  AST_COMMIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !act_q); // R1
  AST_DWORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && kind == AK_DWORD) |=> ($stable(act_q) && $stable(tgt_q) && $stable(dat_q))); // R6
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && kind == AK_WIDE && !wide64 && word == 2'd0) |=> (act_q && dat_q[95:32] == 64'b0)); // R3
endmodule

// File: rtl/wrc_rdpath.sv
module wrc_rdpath
  import wrc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_go,
  input  logic         wide64,
  input  acc_kind_e    kind,
  input  logic [1:0]   word,
  input  logic [127:0] rf_rdata,
  input  logic [63:0]  mem_rdata,
  output logic         rd_valid,
  output logic [63:0]  rd_data
);
  logic [127:0] shd_q, shd_n;
  logic [63:0]  rdd_n;

  always_comb begin
    shd_n = shd_q;
    rdd_n = 64'b0;
    if (rd_go) begin
      unique case (kind)
        AK_WIDE: begin
          if (!wide64) begin
            if (word == 2'd0) begin
              rdd_n = {32'b0, rf_rdata[31:0]};
              shd_n = rf_rdata;
            end else begin
              rdd_n = {32'b0, shd_q[{word, 5'd0} +: 32]};
            end
          end else if (word == 2'd0) begin
            rdd_n = rf_rdata[63:0];
            shd_n = rf_rdata;
          end else if (word == 2'd2) begin
            rdd_n = shd_q[127:64];
          end
        end
        AK_MEM: begin
          if (!wide64) begin
            if (!word[0]) begin
              rdd_n        = {32'b0, mem_rdata[31:0]};
              shd_n[63:0]  = mem_rdata;
            end else begin
              rdd_n = {32'b0, shd_q[63:32]};
            end
          end else if (!word[0]) begin
            rdd_n = mem_rdata;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      shd_q    <= shd_n;
      rd_valid <= rd_go;
      rd_data  <= rdd_n;
    end
  end

  AST_SHADOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> $stable(shd_q)); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && (kind == AK_NONE || kind == AK_DWORD)) |=> (rd_valid && rd_data == 64'b0)); // R11
endmodule

// File: rtl/wide_reg_collector.sv
module wide_reg_collector
  import wrc_pkg::*;
#(
  parameter int PAGE_W       = 2,
  parameter int NUM_WIDE     = 8,
  parameter int DW_SLOT_BASE = 256,
  parameter int NUM_DW       = 3,
  localparam int AW          = 1 + PAGE_W + OFS_W,
  localparam int RIDX_W      = PAGE_W + SLOT_W,
  localparam int DSEL_W      = (NUM_DW > 1) ? $clog2(NUM_DW) : 1,
  localparam int DIDX_W      = PAGE_W + DSEL_W,
  localparam int MIDX_W      = AW - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_wide,
  input  logic [AW-1:0]     bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic              rd_valid,
  output logic [63:0]       rd_data,
  output logic [RIDX_W-1:0] rf_raddr,
  input  logic [127:0]      rf_rdata,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_waddr,
  output logic [127:0]      rf_wdata,
  output logic [MIDX_W-1:0] mem_raddr,
  input  logic [63:0]       mem_rdata,
  output logic              mem_we,
  output logic [MIDX_W-1:0] mem_waddr,
  output logic [63:0]       mem_wdata,
  output logic              dw_we,
  output logic [DIDX_W-1:0] dw_waddr,
  output logic [31:0]       dw_wdata
);
  logic [1:0]        rsync_q;
  logic              rst_core_n;
  acc_kind_e         kind;
  logic [1:0]        word;
  logic [RIDX_W-1:0] ridx;
  logic [DIDX_W-1:0] didx;
  logic [MIDX_W-1:0] midx;
  logic              wr_go, rd_go;

  // Reset asserts at once and releases two clocks later, in step with clk.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  assign wr_go     = bus_valid && bus_write;
  assign rd_go     = bus_valid && !bus_write;
  assign rf_raddr  = ridx;
  assign mem_raddr = midx;

  wrc_decode #(
    .PAGE_W(PAGE_W), .NUM_WIDE(NUM_WIDE),
    .DW_SLOT_BASE(DW_SLOT_BASE), .NUM_DW(NUM_DW)
  ) u_dec (
    .addr(bus_addr), .kind(kind), .word(word),
    .ridx(ridx), .didx(didx), .midx(midx)
  );

  wrc_collect #(
    .RIDX_W(RIDX_W), .MIDX_W(MIDX_W), .DIDX_W(DIDX_W)
  ) u_col (
    .clk(clk), .rst_n(rst_core_n), .wr_go(wr_go), .wide64(bus_wide),
    .kind(kind), .word(word), .ridx(ridx), .didx(didx), .midx(midx),
    .wdata(bus_wdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .dw_we(dw_we), .dw_waddr(dw_waddr), .dw_wdata(dw_wdata)
  );

  wrc_rdpath u_rd (
    .clk(clk), .rst_n(rst_core_n), .rd_go(rd_go), .wide64(bus_wide),
    .kind(kind), .word(word), .rf_rdata(rf_rdata), .mem_rdata(mem_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_valid |-> !(rf_we || mem_we || dw_we)); // R12
endmodule

// File: tb/tb_wide_reg_collector.sv
module tb_wide_reg_collector;
  localparam int AW     = 16;
  localparam int RIDX_W = 11;
  localparam int MIDX_W = 12;
  localparam int DIDX_W = 4;
  localparam int EV_RF = 0, EV_MEM = 1, EV_DW = 2, EV_RD = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              bus_valid, bus_write, bus_wide;
  logic [AW-1:0]     bus_addr;
  logic [63:0]       bus_wdata;
  logic              rd_valid;
  logic [63:0]       rd_data;
  logic [RIDX_W-1:0] rf_raddr, rf_waddr;
  logic [127:0]      rf_rdata, rf_wdata;
  logic              rf_we;
  logic [MIDX_W-1:0] mem_raddr, mem_waddr;
  logic [63:0]       mem_rdata, mem_wdata;
  logic              mem_we;
  logic              dw_we;
  logic [DIDX_W-1:0] dw_waddr;
  logic [31:0]       dw_wdata;

  logic [127:0] rf_model  [0:2047];
  logic [63:0]  mem_model [0:4095];
  assign rf_rdata  = rf_model[rf_raddr];
  assign mem_rdata = mem_model[mem_raddr];

  wide_reg_collector #(
    .PAGE_W(2), .NUM_WIDE(4), .DW_SLOT_BASE(8), .NUM_DW(3)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .dw_we(dw_we), .dw_waddr(dw_waddr), .dw_wdata(dw_wdata)
  );

  typedef struct {
    int           kind;
    int           addr;
    logic [127:0] data;
    string        req;
  } ev_t;

  ev_t q[$];
  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  function automatic logic [15:0] ra(int p, int s, int w);
    return {1'b0, 2'(p), 9'(s), 2'(w), 2'b00};
  endfunction
  function automatic logic [15:0] ma(int i, int h);
    return {1'b1, 12'(i), 1'(h), 2'b00};
  endfunction

  task automatic push(int kind, int addr, logic [127:0] data, string req);
    ev_t e;
    e.kind = kind; e.addr = addr; e.data = data; e.req = req;
    q.push_back(e);
  endtask

  task automatic op(logic wr, logic w64, logic [15:0] a, logic [63:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_wide = w64; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_wide = 1'b0;
  endtask

  task automatic chk(int kind, int addr, logic [127:0] data);
    ev_t e;
    n_chk++;
    if (q.size() == 0) begin
      n_fail++;
      $display("FAIL R12 unexpected event: actual kind %0d addr %0d data %h, expected none",
               kind, addr, data);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.addr != addr || e.data !== data) begin
        n_fail++;
        $display("FAIL %s: actual kind %0d addr %0d data %h, expected kind %0d addr %0d data %h",
                 e.req, kind, addr, data, e.kind, e.addr, e.data);
      end
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Monitor: models the register file and memory, pops expectations on every event.
  initial begin
    for (int i = 0; i < 2048; i++) rf_model[i] = '0;
    for (int i = 0; i < 4096; i++) mem_model[i] = '0;
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && !done) begin
        if (rf_we) begin
          chk(EV_RF, int'(rf_waddr), rf_wdata);
          rf_model[rf_waddr] = rf_wdata;
        end
        if (mem_we) begin
          chk(EV_MEM, int'(mem_waddr), {64'b0, mem_wdata});
          mem_model[mem_waddr] = mem_wdata;
        end
        if (dw_we) chk(EV_DW, int'(dw_waddr), {96'b0, dw_wdata});
        if (rd_valid) chk(EV_RD, 0, {64'b0, rd_data});
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog: actual still running, expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_wide = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    // R12: quiet outputs during reset
    check_bit("R12 rf_we in reset", rf_we, 1'b0);
    check_bit("R12 mem_we in reset", mem_we, 1'b0);
    check_bit("R12 dw_we in reset", dw_we, 1'b0);
    check_bit("R12 rd_valid in reset", rd_valid, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: four 32-bit words, commit on the last one
    op(1, 0, ra(0,1,0), 64'h11110000);
    op(1, 0, ra(0,1,1), 64'h11110001);
    op(1, 0, ra(0,1,2), 64'h11110002);
    push(EV_RF, 1, 128'h11110003_11110002_11110001_11110000, "R1");
    op(1, 0, ra(0,1,3), 64'h11110003);

    // R7: page 3 slot 2
    op(1, 0, ra(3,2,0), 64'h33330000);
    op(1, 0, ra(3,2,1), 64'h33330001);
    op(1, 0, ra(3,2,2), 64'h33330002);
    push(EV_RF, 3*512+2, 128'h33330003_33330002_33330001_33330000, "R7");
    op(1, 0, ra(3,2,3), 64'h33330003);

    // R2: two 64-bit halves; misaligned half ignored
    op(1, 1, ra(1,0,0), 64'hAAAA0001_AAAA0000);
    op(1, 1, ra(1,0,1), 64'hDEAD0000_DEAD0000);
    push(EV_RF, 512, 128'hAAAA0003_AAAA0002_AAAA0001_AAAA0000, "R2");
    op(1, 1, ra(1,0,2), 64'hAAAA0003_AAAA0002);

    // R3: restart discards, stray words dropped
    op(1, 0, ra(0,3,0), 64'h0000B0B0);
    op(1, 0, ra(0,3,1), 64'h0000B1B1);
    op(1, 0, ra(0,3,0), 64'h0000C0C0);
    push(EV_RF, 3, 128'h0000C3C3_00000000_00000000_0000C0C0, "R3");
    op(1, 0, ra(0,3,3), 64'h0000C3C3);
    op(1, 0, ra(0,3,3), 64'h0000D3D3);
    op(1, 0, ra(0,2,0), 64'h0000E0E0);
    op(1, 0, ra(0,3,1), 64'h0000E1E1);
    push(EV_RF, 2, 128'h0000E3E3_00000000_00000000_0000E0E0, "R3");
    op(1, 0, ra(0,2,3), 64'h0000E3E3);

    // R6: dword write in the middle of a collection
    op(1, 0, ra(2,1,0), 64'h0000F0F0);
    op(1, 0, ra(2,1,1), 64'h0000F1F1);
    push(EV_DW, 2*4+1, 128'h5555AAAA, "R6");
    op(1, 0, ra(2,9,0), 64'h5555AAAA);
    op(1, 0, ra(2,1,2), 64'h0000F2F2);
    push(EV_RF, 2*512+1, 128'h0000F3F3_0000F2F2_0000F1F1_0000F0F0, "R6");
    op(1, 0, ra(2,1,3), 64'h0000F3F3);

    // R5: lone dword writes
    push(EV_DW, 0, 128'h00001234, "R5");
    op(1, 0, ra(0,8,0), 64'h00001234);
    push(EV_DW, 1*4+2, 128'h0000ABCD, "R5");
    op(1, 0, ra(1,10,0), 64'h0000ABCD);

    // R4: memory entries
    op(1, 0, ma(5,0), 64'h50500000);
    push(EV_MEM, 5, 128'h50500001_50500000, "R4");
    op(1, 0, ma(5,1), 64'h50500001);
    op(1, 0, ra(0,0,0), 64'h00009090);
    push(EV_MEM, 7, 128'h77770001_77770000, "R4");
    op(1, 1, ma(7,0), 64'h77770001_77770000);
    op(1, 0, ra(0,0,1), 64'h00009191);
    op(1, 0, ra(0,0,2), 64'h00009292);
    push(EV_RF, 0, 128'h00009393_00009292_00009191_00009090, "R4");
    op(1, 0, ra(0,0,3), 64'h00009393);

    // R11: unmapped writes leave an open collection intact
    op(1, 0, ra(1,2,0), 64'h0000A0A0);
    op(1, 0, ra(1,5,0), 64'h00000BAD);
    op(1, 0, ra(1,9,1), 64'h00000BAD);
    op(1, 0, ra(1,2,1) | 16'h0001, 64'h00000BAD);
    push(EV_RF, 512+2, 128'h0000A3A3_00000000_00000000_0000A0A0, "R11");
    op(1, 0, ra(1,2,3), 64'h0000A3A3);
    push(EV_RD, 0, 128'h0, "R11");
    op(0, 0, ra(0,5,0), 64'h0);
    push(EV_RD, 0, 128'h0, "R11");
    op(0, 0, ra(0,8,0), 64'h0);
    push(EV_RD, 0, 128'h0, "R11");
    op(0, 0, ra(0,12,0), 64'h0);

    // R8: snapshot on word 0, later words from the snapshot
    push(EV_RD, 0, 128'h11110000, "R8");
    op(0, 0, ra(0,1,0), 64'h0);
    op(1, 0, ra(0,1,0), 64'h22220000);
    op(1, 0, ra(0,1,1), 64'h22220001);
    op(1, 0, ra(0,1,2), 64'h22220002);
    push(EV_RF, 1, 128'h22220003_22220002_22220001_22220000, "R8");
    op(1, 0, ra(0,1,3), 64'h22220003);
    push(EV_RD, 0, 128'h11110001, "R8");
    op(0, 0, ra(0,1,1), 64'h0);
    push(EV_RD, 0, 128'h11110003, "R8");
    op(0, 0, ra(0,1,3), 64'h0);
    push(EV_RD, 0, 128'h22220000, "R8");
    op(0, 0, ra(0,1,0), 64'h0);
    push(EV_RD, 0, 128'h22220002, "R8");
    op(0, 0, ra(0,1,2), 64'h0);

    // R9: 64-bit reads
    push(EV_RD, 0, 128'hAAAA0001_AAAA0000, "R9");
    op(0, 1, ra(1,0,0), 64'h0);
    push(EV_RD, 0, 128'hAAAA0003_AAAA0002, "R9");
    op(0, 1, ra(1,0,2), 64'h0);

    // R10: memory reads through the snapshot
    push(EV_RD, 0, 128'h50500000, "R10");
    op(0, 0, ma(5,0), 64'h0);
    push(EV_MEM, 5, 128'h60600001_60600000, "R10");
    op(1, 1, ma(5,0), 64'h60600001_60600000);
    push(EV_RD, 0, 128'h50500001, "R10");
    op(0, 0, ma(5,1), 64'h0);
    push(EV_RD, 0, 128'h60600001_60600000, "R10");
    op(0, 1, ma(5,0), 64'h0);

    repeat (4) @(negedge clk);
    // R12: every expected event was seen, none left over
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R12 missing events: actual %0d pending, expected 0", q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule